// File: doc/BRIEF.md
# Channel Address Deinterleaver

This block turns a system address into the address that one memory channel sees. The memory controller and channel are already known when the request arrives. The block searches a small table of address ranges kept per controller and takes the first range that holds the address. It then subtracts the offset programmed for that range and channel. Last, it removes the socket interleave and the channel interleave, each of which packs the ways of one level into a single linear channel space.

Software, or a neighbouring configuration agent, loads the tables through a write-only register port. One request is in flight at a time. When the channel interleave is three-way, a bit-serial restoring divider removes it and the response takes several tens of cycles. Every other way count is handled by shifting, so those responses return in a few cycles. Each response carries the channel address and the two way counts, or an error flag when no range holds the address.

Top module: `chaddr_deinterleave`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0.
- R2: An entry holds an address when (range-start field << 26) <= address <= ((range-end field << 26) | 0x3FFFFFF). Entries are searched only in the table of the requested controller, and the lowest-numbered holding entry wins.
- R3: If no entry holds the address, one `rsp_valid` pulse comes with `rsp_err`=1, `rsp_addr`=0, `rsp_skt_ways`=0 and `rsp_chn_ways`=0.
- R4: Register write encoding, selected by `cfg_sel`. Selector 0 is the range-start word: start field in bits 31:12, channel granularity code in bits 7:6, socket granularity code in bits 5:4. Selector 1 is the range-end word: end field in bits 31:12, socket ways code in bits 11:10, channel ways code in bits 9:8. Selector 2 is the channel offset word: offset field in bits 23:4, stored per controller, channel and entry.
- R5: Granularity codes 0, 1, 2 and 3 select interleave bit 6, 8, 12 and 30.
- R6: On success, `rsp_skt_ways` = 1 << (socket ways code) and `rsp_chn_ways` = (channel ways code) + 1.
- R7: The offset of the requested controller, channel and matched entry (field << 26) is subtracted modulo 2^ADDR_W before any interleave is removed.
- R8: One removal step at bit g with w ways gives (((v >> g) / w) << g) | (L & (2^g - 1)). By default the socket step runs first and the channel step second, and L is the original system address in both steps.
- R9: When the channel ways equal 3 and the socket interleave bit is above the channel interleave bit, the channel step runs first and the socket step second, and L is the step's own input value.
- R10: `req_ready` is low from the cycle after an accepted request until its response. Requests presented while `req_ready` is low are ignored, and each accepted request produces exactly one `rsp_valid` pulse.
- R11: A response arrives no more than ADDR_W+4 cycles after its request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Word select: 0 range start, 1 range end, 2 channel offset |
| cfg_ctl | input | CTL_W | Controller table written |
| cfg_chn | input | CHN_W | Channel (offset words only) |
| cfg_idx | input | IDX_W | Entry index |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block idle, request will be taken |
| req_addr | input | ADDR_W | System address |
| req_ctl | input | CTL_W | Decoded controller |
| req_chn | input | CHN_W | Decoded channel |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | No range held the address |
| rsp_addr | output | ADDR_W | Channel address |
| rsp_skt_ways | output | 4 | Socket ways (1, 2, 4, 8) |
| rsp_chn_ways | output | 3 | Channel ways (1 to 4) |

## Verification
The hardest case to reach is the reversed removal order. It needs three-way channel interleave and a socket bit above the channel bit at the same time, and its effect shows only in the bits that the low-bit source refills. The bench therefore sweeps every combination of the two granularity codes and the two way codes on one entry. It sends addresses from each channel, each with its own offset, and checks against a model that applies both orderings arithmetically. Range boundaries, overlapping entries, and requests made while the divider is busy are driven explicitly.

// File: rtl/chaddr_pkg.sv
package chaddr_pkg;

    localparam int FLD_W   = 20;
    localparam int FLD_LSB = 26;

    typedef enum logic [1:0] {
        CFG_START = 2'd0,
        CFG_END   = 2'd1,
        CFG_OFS   = 2'd2
    } cfg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_DIV  = 2'd2
    } state_e;

    function automatic logic [4:0] gran_to_bit(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd6;
            2'd1:    return 5'd8;
            2'd2:    return 5'd12;
            default: return 5'd30;
        endcase
    endfunction

endpackage

// File: rtl/chaddr_cfg_store.sv
module chaddr_cfg_store
    import chaddr_pkg::*;
#(
    parameter int CTRLS   = 2,
    parameter int CHANS   = 3,
    parameter int ENTRIES = 8,
    localparam int CTL_W  = (CTRLS > 1) ? $clog2(CTRLS) : 1,
    localparam int CHN_W  = (CHANS > 1) ? $clog2(CHANS) : 1,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [1:0]                    sel,
    input  logic [CTL_W-1:0]              wctl,
    input  logic [CHN_W-1:0]              wchn,
    input  logic [IDX_W-1:0]              widx,
    input  logic [31:0]                   wdata,
    input  logic [CTL_W-1:0]              rctl,
    input  logic [CHN_W-1:0]              rchn,
    output logic [ENTRIES-1:0][FLD_W-1:0] start_f,
    output logic [ENTRIES-1:0][FLD_W-1:0] end_f,
    output logic [ENTRIES-1:0][FLD_W-1:0] ofs_f,
    output logic [ENTRIES-1:0][1:0]       sg_f,
    output logic [ENTRIES-1:0][1:0]       cg_f,
    output logic [ENTRIES-1:0][1:0]       sw_f,
    output logic [ENTRIES-1:0][1:0]       cw_f
);

    logic [FLD_W-1:0] start_q [CTRLS][ENTRIES];
    logic [FLD_W-1:0] end_q   [CTRLS][ENTRIES];
    logic [FLD_W-1:0] ofs_q   [CTRLS][CHANS][ENTRIES];
    logic [1:0]       sg_q    [CTRLS][ENTRIES];
    logic [1:0]       cg_q    [CTRLS][ENTRIES];
    logic [1:0]       sw_q    [CTRLS][ENTRIES];
    logic [1:0]       cw_q    [CTRLS][ENTRIES];

    logic unused_wbits;
    assign unused_wbits = ^wdata[3:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < CTRLS; c++) begin
                for (int e = 0; e < ENTRIES; e++) begin
                    start_q[c][e] <= '0;
                    end_q[c][e]   <= '0;
                    sg_q[c][e]    <= '0;
                    cg_q[c][e]    <= '0;
                    sw_q[c][e]    <= '0;
                    cw_q[c][e]    <= '0;
                    for (int h = 0; h < CHANS; h++) ofs_q[c][h][e] <= '0;
                end
            end
        end else if (we && (int'(wctl) < CTRLS) && (int'(widx) < ENTRIES)) begin
            case (sel)
                CFG_START: begin
                    start_q[wctl][widx] <= wdata[31:12];
                    cg_q[wctl][widx]    <= wdata[7:6];
                    sg_q[wctl][widx]    <= wdata[5:4];
                end
                CFG_END: begin
                    end_q[wctl][widx] <= wdata[31:12];
                    sw_q[wctl][widx]  <= wdata[11:10];
                    cw_q[wctl][widx]  <= wdata[9:8];
                end
                CFG_OFS: begin
                    if (int'(wchn) < CHANS) ofs_q[wctl][wchn][widx] <= wdata[23:4];
                end
                default: ;
            endcase
        end
    end

    logic [CTL_W-1:0] ctl_s;
    logic [CHN_W-1:0] chn_s;
    assign ctl_s = (int'(rctl) < CTRLS) ? rctl : '0;
    assign chn_s = (int'(rchn) < CHANS) ? rchn : '0;

    always_comb begin
        for (int e = 0; e < ENTRIES; e++) begin
            start_f[e] = start_q[ctl_s][e];
            end_f[e]   = end_q[ctl_s][e];
            ofs_f[e]   = ofs_q[ctl_s][chn_s][e];
            sg_f[e]    = sg_q[ctl_s][e];
            cg_f[e]    = cg_q[ctl_s][e];
            sw_f[e]    = sw_q[ctl_s][e];
            cw_f[e]    = cw_q[ctl_s][e];
        end
    end

endmodule

// File: rtl/chaddr_range_match.sv
module chaddr_range_match
    import chaddr_pkg::*;
#(
    parameter int ADDR_W  = 46,
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ADDR_W-1:0]             addr,
    input  logic [ENTRIES-1:0][FLD_W-1:0] start_f,
    input  logic [ENTRIES-1:0][FLD_W-1:0] end_f,
    output logic                          hit,
    output logic [IDX_W-1:0]              idx
);

    localparam logic [ADDR_W-1:0] LOW_ONES = (ADDR_W'(1) << FLD_LSB) - ADDR_W'(1);

    logic [ENTRIES-1:0] in_rng;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        logic [ADDR_W-1:0] lo, hi;
        assign lo        = ADDR_W'(start_f[e]) << FLD_LSB;
        assign hi        = (ADDR_W'(end_f[e]) << FLD_LSB) | LOW_ONES;
        assign in_rng[e] = (lo <= addr) && (addr <= hi);
    end

    always_comb begin
        idx = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (in_rng[e]) idx = IDX_W'(e);
        end
    end

    assign hit = |in_rng;

endmodule

// File: rtl/chaddr_deinterleave.sv
module chaddr_deinterleave
    import chaddr_pkg::*;
#(
    parameter int ADDR_W  = 46,
    parameter int CTRLS   = 2,
    parameter int CHANS   = 3,
    parameter int ENTRIES = 8,
    localparam int CTL_W  = (CTRLS > 1) ? $clog2(CTRLS) : 1,
    localparam int CHN_W  = (CHANS > 1) ? $clog2(CHANS) : 1,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [CTL_W-1:0]  cfg_ctl,
    input  logic [CHN_W-1:0]  cfg_chn,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [31:0]       cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CTL_W-1:0]  req_ctl,
    input  logic [CHN_W-1:0]  req_chn,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [3:0]        rsp_skt_ways,
    output logic [2:0]        rsp_chn_ways
);

    localparam int CNT_W = $clog2(ADDR_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_W - 1);

    typedef struct packed {
        state_e            st;
        logic              step;
        logic              chn_first;
        logic [ADDR_W-1:0] val;
        logic [ADDR_W-1:0] orig;
        logic [4:0]        sgb;
        logic [4:0]        cgb;
        logic [1:0]        swc;
        logic [1:0]        cwc;
        logic [ADDR_W-1:0] dq;
        logic [1:0]        rem;
        logic [CNT_W-1:0]  cnt;
        logic              rsp_v;
        logic              rsp_e;
        logic [ADDR_W-1:0] rsp_a;
        logic [3:0]        rsp_sw;
        logic [2:0]        rsp_cw;
    } state_t;

    state_t s_q, s_d;

    logic [ENTRIES-1:0][FLD_W-1:0] start_f, end_f, ofs_f;
    logic [ENTRIES-1:0][1:0]       sg_f, cg_f, sw_f, cw_f;
    logic                          hit;
    logic [IDX_W-1:0]              hit_idx;

    chaddr_cfg_store #(
        .CTRLS(CTRLS), .CHANS(CHANS), .ENTRIES(ENTRIES)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .we(cfg_we), .sel(cfg_sel), .wctl(cfg_ctl), .wchn(cfg_chn),
        .widx(cfg_idx), .wdata(cfg_wdata),
        .rctl(req_ctl), .rchn(req_chn),
        .start_f(start_f), .end_f(end_f), .ofs_f(ofs_f),
        .sg_f(sg_f), .cg_f(cg_f), .sw_f(sw_f), .cw_f(cw_f)
    );

    chaddr_range_match #(
        .ADDR_W(ADDR_W), .ENTRIES(ENTRIES)
    ) u_match (
        .addr(req_addr), .start_f(start_f), .end_f(end_f),
        .hit(hit), .idx(hit_idx)
    );

    // current removal step context
    logic              is_chn, need_div, step_done;
    logic [4:0]        g;
    logic [1:0]        k;
    logic [ADDR_W-1:0] low_src, low_mask, shifted, step_res;
    logic [2:0]        r_sh;
    logic              r_ge;
    logic [1:0]        rem_n;
    logic [ADDR_W-1:0] dq_n;

    always_comb begin
        is_chn   = s_q.chn_first ? ~s_q.step : s_q.step;
        g        = is_chn ? s_q.cgb : s_q.sgb;
        low_src  = s_q.chn_first ? s_q.val : s_q.orig;
        low_mask = (ADDR_W'(1) << g) - ADDR_W'(1);
        shifted  = s_q.val >> g;
        need_div = is_chn && (s_q.cwc == 2'd2);
        if (is_chn) k = (s_q.cwc == 2'd3) ? 2'd2 : s_q.cwc;
        else        k = s_q.swc;

        r_sh  = {s_q.rem, s_q.dq[ADDR_W-1]};
        r_ge  = (r_sh >= 3'd3);
        rem_n = r_ge ? 2'(r_sh - 3'd3) : r_sh[1:0];
        dq_n  = {s_q.dq[ADDR_W-2:0], r_ge};

        s_d       = s_q;
        s_d.rsp_v = 1'b0;
        step_done = 1'b0;
        step_res  = '0;

        case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!hit) begin
                        s_d.rsp_v  = 1'b1;
                        s_d.rsp_e  = 1'b1;
                        s_d.rsp_a  = '0;
                        s_d.rsp_sw = '0;
                        s_d.rsp_cw = '0;
                    end else begin
                        s_d.orig      = req_addr;
                        s_d.val       = req_addr - (ADDR_W'(ofs_f[hit_idx]) << FLD_LSB);
                        s_d.sgb       = gran_to_bit(sg_f[hit_idx]);
                        s_d.cgb       = gran_to_bit(cg_f[hit_idx]);
                        s_d.swc       = sw_f[hit_idx];
                        s_d.cwc       = cw_f[hit_idx];
                        s_d.chn_first = (cw_f[hit_idx] == 2'd2) &&
                                        (gran_to_bit(sg_f[hit_idx]) > gran_to_bit(cg_f[hit_idx]));
                        s_d.step      = 1'b0;
                        s_d.st        = ST_STEP;
                    end
                end
            end
            ST_STEP: begin
                if (need_div) begin
                    s_d.dq  = shifted;
                    s_d.rem = '0;
                    s_d.cnt = '0;
                    s_d.st  = ST_DIV;
                end else begin
                    step_done = 1'b1;
                    step_res  = ((shifted >> k) << g) | (low_src & low_mask);
                end
            end
            ST_DIV: begin
                s_d.dq  = dq_n;
                s_d.rem = rem_n;
                s_d.cnt = s_q.cnt + 1'b1;
                if (s_q.cnt == CNT_LAST) begin
                    step_done = 1'b1;
                    step_res  = (dq_n << g) | (low_src & low_mask);
                end
            end
            default: s_d.st = ST_IDLE;
        endcase

        if (step_done) begin
            if (s_q.step) begin
                s_d.rsp_v  = 1'b1;
                s_d.rsp_e  = 1'b0;
                s_d.rsp_a  = step_res;
                s_d.rsp_sw = 4'd1 << s_q.swc;
                s_d.rsp_cw = {1'b0, s_q.cwc} + 3'd1;
                s_d.st     = ST_IDLE;
            end else begin
                s_d.val  = step_res;
                s_d.step = 1'b1;
                s_d.st   = ST_STEP;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready    = (s_q.st == ST_IDLE);
    assign rsp_valid    = s_q.rsp_v;
    assign rsp_err      = s_q.rsp_e;
    assign rsp_addr     = s_q.rsp_a;
    assign rsp_skt_ways = s_q.rsp_sw;
    assign rsp_chn_ways = s_q.rsp_cw;

endmodule

// File: rtl/chaddr_deinterleave_chk.sv
module chaddr_deinterleave_chk #(
    parameter int ADDR_W = 46
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [ADDR_W-1:0] rsp_addr,
    input logic [3:0]        rsp_skt_ways,
    input logic [2:0]        rsp_chn_ways
);

    localparam int LAT_MAX = ADDR_W + 4;

    int busy_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          busy_cnt <= 0;
        else if (req_ready)  busy_cnt <= 0;
        else                 busy_cnt <= busy_cnt + 1;
    end

    // R3
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_addr == '0 && rsp_skt_ways == 4'd0 && rsp_chn_ways == 3'd0));

    // R6
    ways_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err) |-> ($countones(rsp_skt_ways) == 1 &&
                                     rsp_chn_ways >= 3'd1 && rsp_chn_ways <= 3'd4));

    // R10
    rsp_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);

    // R10
    accept_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready || rsp_valid));

    // R10
    busy_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_ready) |-> $past(req_valid));

    // R11
    latency_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= LAT_MAX);

endmodule

bind chaddr_deinterleave chaddr_deinterleave_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_addr(rsp_addr),
    .rsp_skt_ways(rsp_skt_ways), .rsp_chn_ways(rsp_chn_ways)
);

// File: tb/tb_chaddr_deinterleave.sv
module tb_chaddr_deinterleave;

    localparam int AW = 46;
    localparam logic [63:0] AMASK = (64'd1 << AW) - 64'd1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic          cfg_ctl = '0;
    logic [1:0]    cfg_chn = '0;
    logic [2:0]    cfg_idx = '0;
    logic [31:0]   cfg_wdata = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          req_ctl = '0;
    logic [1:0]    req_chn = '0;
    logic          rsp_valid, rsp_err;
    logic [AW-1:0] rsp_addr;
    logic [3:0]    rsp_skt_ways;
    logic [2:0]    rsp_chn_ways;

    always #2 clk = ~clk;

    chaddr_deinterleave dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_ctl(cfg_ctl), .cfg_chn(cfg_chn),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_ctl(req_ctl), .req_chn(req_chn),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_addr(rsp_addr),
        .rsp_skt_ways(rsp_skt_ways), .rsp_chn_ways(rsp_chn_ways)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    logic [19:0] sh_start [2][8];
    logic [19:0] sh_end   [2][8];
    logic [1:0]  sh_sg [2][8];
    logic [1:0]  sh_cg [2][8];
    logic [1:0]  sh_sw [2][8];
    logic [1:0]  sh_cw [2][8];
    logic [19:0] sh_ofs [2][3][8];

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input int ctl, input int chn, input int idx, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_ctl = ctl[0]; cfg_chn = chn[1:0];
        cfg_idx = idx[2:0]; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // R4 word layouts
    task automatic set_entry(input int ctl, input int e, input logic [19:0] st, input logic [19:0] en,
                             input logic [1:0] sg, input logic [1:0] cg, input logic [1:0] sw, input logic [1:0] cw);
        wr(2'd0, ctl, 0, e, {st, 4'b0, cg, sg, 4'b0});
        wr(2'd1, ctl, 0, e, {en, sw, cw, 8'b0});
        sh_start[ctl][e] = st; sh_end[ctl][e] = en;
        sh_sg[ctl][e] = sg; sh_cg[ctl][e] = cg; sh_sw[ctl][e] = sw; sh_cw[ctl][e] = cw;
    endtask

    task automatic set_ofs(input int ctl, input int chn, input int e, input logic [19:0] o);
        wr(2'd2, ctl, chn, e, {8'b0, o, 4'b0});
        sh_ofs[ctl][chn][e] = o;
    endtask

    function automatic int gbit(input logic [1:0] c);
        case (c)
            2'd0: return 6;
            2'd1: return 8;
            2'd2: return 12;
            default: return 30;
        endcase
    endfunction

    function automatic logic [63:0] strip(input logic [63:0] v, input int sh, input int w, input logic [63:0] lo);
        return (((v >> sh) / 64'(w)) << sh) | (lo & ((64'd1 << sh) - 64'd1));
    endfunction

    function automatic void model(input logic [63:0] a, input int ctl, input int chn,
                                  output bit err, output logic [63:0] ca, output int sw, output int cw);
        int hit = -1;
        int sb, cb;
        logic [63:0] lo, hi, v;
        for (int e = 0; e < 8; e++) begin
            lo = 64'(sh_start[ctl][e]) << 26;
            hi = (64'(sh_end[ctl][e]) << 26) | 64'h3FF_FFFF;
            if (hit < 0 && lo <= a && a <= hi) hit = e;
        end
        err = (hit < 0); ca = 0; sw = 0; cw = 0;
        if (!err) begin
            sw = 1 << sh_sw[ctl][hit];
            cw = int'(sh_cw[ctl][hit]) + 1;
            sb = gbit(sh_sg[ctl][hit]);
            cb = gbit(sh_cg[ctl][hit]);
            v = (a - (64'(sh_ofs[ctl][chn][hit]) << 26)) & AMASK;
            if (cw == 3 && sb > cb) begin
                v = strip(v, cb, cw, v);
                v = strip(v, sb, sw, v);
            end else begin
                v = strip(v, sb, sw, a);
                v = strip(v, cb, cw, a);
            end
            ca = v & AMASK;
        end
    endfunction

    task automatic run_req(input logic [63:0] a, input int ctl, input int chn, input string tag);
        bit e_err; logic [63:0] e_ca; int e_sw, e_cw;
        int lat; bit got;
        model(a, ctl, chn, e_err, e_ca, e_sw, e_cw);
        @(negedge clk);
        req_addr = a[AW-1:0]; req_ctl = ctl[0]; req_chn = chn[1:0]; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1; got = 0;
        while (!got && lat < 200) begin
            if (rsp_valid) got = 1;
            else begin @(negedge clk); lat++; end
        end
        check(got, "R10 response pulse", 64'(got), 64'd1);
        check(lat <= AW + 4, "R11 latency", 64'(lat), 64'(AW + 4));
        check(rsp_err == e_err, {tag, " err"}, 64'(rsp_err), 64'(e_err));
        check(64'(rsp_addr) == e_ca, {tag, " addr"}, 64'(rsp_addr), e_ca);
        check(int'(rsp_skt_ways) == e_sw && int'(rsp_chn_ways) == e_cw, {tag, " R6 ways"},
              {32'(rsp_skt_ways), 32'(rsp_chn_ways)}, {32'(e_sw), 32'(e_cw)});
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL R11 watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 2; c++)
            for (int e = 0; e < 8; e++) begin
                sh_start[c][e] = 0; sh_end[c][e] = 0; sh_sg[c][e] = 0; sh_cg[c][e] = 0;
                sh_sw[c][e] = 0; sh_cw[c][e] = 0;
                for (int h = 0; h < 3; h++) sh_ofs[c][h][e] = 0;
            end
        repeat (3) @(negedge clk);
        // R1
        check(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 reset state", {req_ready, rsp_valid}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);

        // controller 0: entry0 covers low 4 GiB, 2-way socket at bit 8
        set_entry(0, 0, 20'h0, 20'h3F, 2'd1, 2'd0, 2'd1, 2'd0);
        for (int e = 1; e < 8; e++) set_entry(0, e, 20'hFFFFF, 20'h0, 0, 0, 0, 0);
        // controller 1 layout
        set_entry(1, 0, 20'h0, 20'h3, 2'd0, 2'd1, 2'd0, 2'd1);
        set_entry(1, 1, 20'h4, 20'h7, 2'd2, 2'd0, 2'd2, 2'd3);
        set_entry(1, 2, 20'h8, 20'h3F, 2'd3, 2'd0, 2'd1, 2'd2);
        set_entry(1, 3, 20'h4, 20'h7, 2'd0, 2'd0, 2'd3, 2'd0);
        for (int e = 4; e < 8; e++) set_entry(1, e, 20'hFFFFF, 20'h0, 0, 0, 0, 0);
        set_ofs(1, 0, 2, 20'h1);
        set_ofs(1, 1, 2, 20'h3);
        set_ofs(1, 2, 2, 20'h7);
        set_ofs(1, 1, 1, 20'h2);
        set_ofs(0, 2, 0, 20'h5);

        // R2 boundaries and priority (entry1 beats overlapping entry3)
        run_req(64'h0FFF_FFFF, 1, 0, "R2 top of entry0");
        run_req(64'h1000_0000, 1, 0, "R2 bottom of entry1");
        run_req(64'h1FFF_FFFF, 1, 1, "R2 top of entry1 priority");
        run_req(64'h2000_0000, 1, 1, "R2 bottom of entry2");
        run_req(64'h1234_5678, 0, 1, "R2 controller 0 table");
        // R7 offset on controller 0 channel 2 wraps below zero
        run_req(64'h0123_4567, 0, 2, "R7 wrapping offset");
        // R3 no match
        run_req(64'h1_0000_0000, 1, 0, "R3 above all ranges");
        run_req(64'h3F_0000_0000, 0, 2, "R3 far address");

        // R4 R5 R8 R9 R7: sweep all codes on entry2 of controller 1
        for (int sg = 0; sg < 4; sg++)
            for (int cg = 0; cg < 4; cg++)
                for (int sw = 0; sw < 4; sw++)
                    for (int cw = 0; cw < 4; cw++) begin
                        set_entry(1, 2, 20'h8, 20'h3F, sg[1:0], cg[1:0], sw[1:0], cw[1:0]);
                        for (int ch = 0; ch < 3; ch++) begin
                            run_req(64'h2ABC_DEF5 + 64'(sg * 64'h1111 + cg * 64'h2345 + ch * 64'h10_0C01),
                                    1, ch, (cw == 2 && gbit(sg[1:0]) > gbit(cg[1:0])) ? "R9 sweep" : "R8 sweep");
                            run_req(64'hF7FF_FFC3 - 64'(sw * 64'h3_3001 + cw * 64'h777),
                                    1, ch, "R5 R7 sweep");
                        end
                    end

        // R10: requests while busy are ignored (three-way channel path is long)
        set_entry(1, 2, 20'h8, 20'h3F, 2'd3, 2'd0, 2'd1, 2'd2);
        begin
            bit e_err; logic [63:0] e_ca; int e_sw, e_cw; int extra; bit got;
            model(64'h3456_789B, 1, 2, e_err, e_ca, e_sw, e_cw);
            @(negedge clk);
            req_addr = 46'h3456_789B; req_ctl = 1'b1; req_chn = 2'd2; req_valid = 1'b1;
            @(negedge clk);
            check(req_ready == 1'b0, "R10 ready low when busy", 64'(req_ready), 64'd0);
            req_addr = 46'h5_0000_0000; req_chn = 2'd0;
            got = 0;
            for (int i = 0; i < 120 && !got; i++) begin
                if (rsp_valid) got = 1; else @(negedge clk);
            end
            req_valid = 1'b0;
            check(got && rsp_err == 1'b0 && 64'(rsp_addr) == e_ca, "R10 first request served",
                  64'(rsp_addr), e_ca);
            extra = 0;
            @(negedge clk);
            for (int i = 0; i < 100; i++) begin
                if (rsp_valid) extra++;
                @(negedge clk);
            end
            check(extra == 0, "R10 single response", 64'(extra), 64'd0);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule